// File: doc/BRIEF.md
# VGA Extended Register Port Decoder

This block is the host-side register file of a VGA-compatible display controller that carries a handful of vendor extensions. It accepts 8-bit I/O requests on a valid/ready channel. It decodes the miscellaneous-output port, the graphics-controller index/data pair, the CRTC index/data pair and two memory-bank ports. It keeps the resulting register contents and drives them out to the rest of the controller. Sequencer, attribute and palette ports are handled elsewhere. Any address this block does not claim reads back as 0xFF, and a write to such an address is dropped.

Bit 0 of the miscellaneous-output register selects colour or mono addressing. With the bit clear, every address in the 0x3B0–0x3BF and 0x3D0–0x3DF groups is XORed with 0x60 before decoding. The CRTC pair then answers at 0x3B4/0x3B5, and the same group at 0x3Dx goes unclaimed. The block enforces the CRTC write lock. It synthesizes read values for the chip-type and memory-size fields. It recomputes the display start address when its halves change, and it pulses a strobe whenever a write should cause the timing logic to recalculate. The two bank ports select a 64 KB window for writes and, optionally, a separate one for reads.

Read requests get a single-byte response on a second valid/ready channel. The response appears in the cycle after the request is accepted and is held until it is taken. A new request is accepted only while no response is waiting, or in the same cycle the waiting one is taken. Writes produce no response.

Top module: `vga_xreg_decoder`

## Requirements
- R1: After reset the miscellaneous-output register is 0x01 (colour addressing), all CRTC, graphics and bank registers, both indices and the start address are zero, no strobe is high, rsp_valid is low and req_ready is high.
- R2: With miscellaneous-output bit 0 clear, an address in 0x3B0–0x3BF or 0x3D0–0x3DF is XORed with 0x60 before decoding. With the bit set, addresses are decoded as given. An unclaimed address reads 0xFF and a write to it has no effect.
- R3: A write to the CRTC index port (0x3D4 in colour mode) keeps only data bits 5:0 as the index, and a read of that port returns the index zero-extended.
- R4: A write to the graphics data port (0x3CF) is stored only when the graphics index (port 0x3CE) is 9 or more and below GDC_N. A read of the data port at any index outside that range returns 0xFF.
- R5: While CRTC register 0x11 bit 7 is set, writes to CRTC indices 0 to 6 are dropped.
- R6: While CRTC register 0x11 bit 7 is set, a write to CRTC index 7 updates only bit 4 and leaves bits 7:5 and 3:0 unchanged.
- R7: A read of CRTC index 0x1A returns CHIP_TYPE in bits 7:6 and zero below, whatever was written there.
- R8: A read of CRTC index 0x1E returns 2 when MEM_KB is 1024, 1 when MEM_KB is 512, and 0 otherwise.
- R9: A read of graphics index 0x0C returns the stored byte with bit 2 forced to 1.
- R10: A write to CRTC index 0x0C or 0x0D that changes the stored byte raises start_load for one cycle, in the cycle after the write is accepted. In that cycle start_addr is {CRTC 0x0C, CRTC 0x0D} plus CRTC 0x08 bits 6:5. A write that leaves the byte unchanged does not raise start_load.
- R11: recalc pulses for one cycle after a CRTC write that changes the stored byte at any index other than 0x0C to 0x10. It also pulses after any graphics data write to index 0x0B or 0x0C, changed or not. It stays low after an unchanged CRTC write and after any write to CRTC 0x0C–0x10.
- R12: write_bank is bits 3:0 of bank port 0x3D7. read_bank is bits 3:0 of bank port 0x3D6 when graphics register 0x0F bit 2 is set, and equals write_bank otherwise. Both bank ports read back the full byte written.
- R13: req_ready equals (not rsp_valid) or rsp_ready. A read accepted at one clock edge gives rsp_valid with its data after that edge. The response stays valid, with the data unchanged, until rsp_ready is high at an edge.
- R14: Writing port 0x3C2 loads the miscellaneous-output register, and reading port 0x3CC returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Read response data |
| misc_out | output | 8 | Miscellaneous-output register |
| crtc_regs | output | 8·2^CRTC_IW (512) | All CRTC registers, index i in bits 8i+7:8i |
| gfx_regs | output | 8·GDC_N (128) | Graphics registers, index i in bits 8i+7:8i (0–8 stay zero) |
| read_bank | output | BANK_W (4) | Bank for memory reads |
| write_bank | output | BANK_W (4) | Bank for memory writes |
| start_addr | output | 17 | Display start-address latch |
| start_load | output | 1 | One-cycle pulse: start_addr reloaded |
| recalc | output | 1 | One-cycle pulse: timing must be recalculated |

## Verification
Two things can meet in the same clock edge. One is the host taking a waiting read response; the other is the acceptance of the next request, which the ready rule allows only because the drain and the new accept share that edge. The bench holds rsp_ready low after a read and keeps a second read request pending. It confirms that req_ready stays low and the first byte stays put. It then raises rsp_ready with the request still valid and expects rsp_valid still high after that edge, now carrying the second register's value. A second such meeting is judged in the start-address path. A changed write to CRTC 0x0C must raise start_load and leave recalc low in the same cycle, while a changed write to 0x08 must do the reverse.

// File: rtl/vga_xreg_pkg.sv
package vga_xreg_pkg;

  typedef enum logic [3:0] {
    PORT_NONE,
    PORT_MISC_WR,
    PORT_MISC_RD,
    PORT_GDC_IDX,
    PORT_GDC_DAT,
    PORT_CRTC_IDX,
    PORT_CRTC_DAT,
    PORT_BANK_RD,
    PORT_BANK_WR
  } port_e;

  // Mono addressing folds the 0x3Bx and 0x3Dx groups onto each other.
  function automatic logic [15:0] fold_addr(input logic [15:0] a, input logic colour);
    logic grp;
    grp = (a[15:4] == 12'h03D) || (a[15:4] == 12'h03B);
    return (grp && !colour) ? (a ^ 16'h0060) : a;
  endfunction

  function automatic logic [1:0] mem_size_code(input int kb);
    if (kb == 1024) return 2'd2;
    else if (kb == 512) return 2'd1;
    else return 2'd0;
  endfunction

endpackage

// File: rtl/vga_xreg_port_map.sv
module vga_xreg_port_map
  import vga_xreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        write,
  input  logic        colour,
  output port_e       port
);

  logic [15:0] eff;

  always_comb begin
    eff  = fold_addr(addr, colour);
    port = PORT_NONE;
    case (eff)
      16'h03C2: if (write)  port = PORT_MISC_WR;
      16'h03CC: if (!write) port = PORT_MISC_RD;
      16'h03CE: port = PORT_GDC_IDX;
      16'h03CF: port = PORT_GDC_DAT;
      16'h03D4: port = PORT_CRTC_IDX;
      16'h03D5: port = PORT_CRTC_DAT;
      16'h03D6: port = PORT_BANK_RD;
      16'h03D7: port = PORT_BANK_WR;
      default:  port = PORT_NONE;
    endcase
  end

  // In mono mode the raw colour CRTC index address is not claimed
  assert_mono_hides_colour_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!colour && addr == 16'h03D4) |-> port == PORT_NONE);

  // In mono mode the mono address reaches the CRTC index port
  assert_mono_reaches_crtc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!colour && addr == 16'h03B4) |-> port == PORT_CRTC_IDX);

endmodule

// File: rtl/vga_xreg_crtc_file.sv
module vga_xreg_crtc_file
  import vga_xreg_pkg::*;
#(
  parameter int CHIP_TYPE = 2,
  parameter int MEM_KB    = 1024,
  parameter int IDX_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idx_wr,
  input  logic                     dat_wr,
  input  logic [7:0]               wdata,
  output logic [IDX_W-1:0]         idx_q,
  output logic [7:0]               rd_data,
  output logic [(8<<IDX_W)-1:0]    regs_flat,
  output logic [16:0]              start_addr,
  output logic                     start_load,
  output logic                     recalc
);

  localparam int N = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_LOCK7 = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_PRSET = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_STHI  = IDX_W'(8'h0C);
  localparam logic [IDX_W-1:0] I_STLO  = IDX_W'(8'h0D);
  localparam logic [IDX_W-1:0] I_CURLO = IDX_W'(8'h0E);
  localparam logic [IDX_W-1:0] I_CUREND= IDX_W'(8'h10);
  localparam logic [IDX_W-1:0] I_PROT  = IDX_W'(8'h11);
  localparam logic [IDX_W-1:0] I_CHIP  = IDX_W'(8'h1A);
  localparam logic [IDX_W-1:0] I_MEM   = IDX_W'(8'h1E);
  localparam logic [1:0]       CHIP_CODE = 2'(CHIP_TYPE);
  localparam logic [1:0]       MEM_CODE  = mem_size_code(MEM_KB);

  logic [7:0]  regs_q [N];
  logic [7:0]  old_val, new_val, hi_val, lo_val;
  logic        locked, lock_low, merge7, commit, changed, hit_start, skip_rng;
  logic [16:0] start_next;
  logic        start_load_q, recalc_q;
  logic [16:0] start_q;

  always_comb begin
    old_val   = regs_q[idx_q];
    locked    = regs_q[I_PROT][7];
    lock_low  = locked && (idx_q < I_LOCK7);
    merge7    = locked && (idx_q == I_LOCK7);
    new_val   = merge7 ? {old_val[7:5], wdata[4], old_val[3:0]} : wdata;
    commit    = dat_wr && !lock_low;
    changed   = commit && (new_val != old_val);
    hit_start = (idx_q == I_STHI) || (idx_q == I_STLO);
    skip_rng  = (idx_q >= I_CURLO) && (idx_q <= I_CUREND);
    hi_val    = (idx_q == I_STHI) ? new_val : regs_q[I_STHI];
    lo_val    = (idx_q == I_STLO) ? new_val : regs_q[I_STLO];
    start_next = {1'b0, hi_val, lo_val} + {15'b0, regs_q[I_PRSET][6:5]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q        <= '0;
      start_q      <= '0;
      start_load_q <= 1'b0;
      recalc_q     <= 1'b0;
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata[IDX_W-1:0];
      if (commit) regs_q[idx_q] <= new_val;
      start_load_q <= changed && hit_start;
      recalc_q     <= changed && !hit_start && !skip_rng;
      if (changed && hit_start) start_q <= start_next;
    end
  end

  always_comb begin
    if (idx_q == I_CHIP)      rd_data = {CHIP_CODE, 6'b0};
    else if (idx_q == I_MEM)  rd_data = {6'b0, MEM_CODE};
    else                      rd_data = regs_q[idx_q];
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = regs_q[g];
  end

  assign start_addr = start_q;
  assign start_load = start_load_q;
  assign recalc     = recalc_q;

  // Index keeps only the low bits of the written byte
  assert_index_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(wdata[IDX_W-1:0]));

  // Locked timing registers do not move
  assert_lock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && lock_low) |=> rd_data == $past(rd_data));

  // Index 7 under lock keeps every bit but bit 4
  assert_lock_idx7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && merge7) |=> (regs_q[I_LOCK7][7:5] == $past(regs_q[I_LOCK7][7:5]))
                        && (regs_q[I_LOCK7][3:0] == $past(regs_q[I_LOCK7][3:0])));

  // A start reload follows a data write and never comes with a recalc pulse
  assert_start_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_load_q |-> ($past(dat_wr) && !recalc_q));

  // A recalc pulse is caused only by a data write
  assert_recalc_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    recalc_q |-> $past(dat_wr));

endmodule

// File: rtl/vga_xreg_gfx_file.sv
module vga_xreg_gfx_file #(
  parameter int GDC_N  = 16,
  parameter int BANK_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic                 dat_wr,
  input  logic                 bank_rd_wr,
  input  logic                 bank_wr_wr,
  input  logic [7:0]           wdata,
  output logic [7:0]           idx_q,
  output logic [7:0]           rd_data,
  output logic [8*GDC_N-1:0]   regs_flat,
  output logic [7:0]           bank_rd_q,
  output logic [7:0]           bank_wr_q,
  output logic [BANK_W-1:0]    read_bank,
  output logic [BANK_W-1:0]    write_bank,
  output logic                 recalc
);

  localparam int         IW      = $clog2(GDC_N);
  localparam logic [8:0] LIMIT   = 9'(GDC_N);
  localparam logic [7:0] I_FIRST = 8'h09;
  localparam logic [7:0] I_TIMA  = 8'h0B;
  localparam logic [7:0] I_TIMB  = 8'h0C;
  localparam logic [IW-1:0] I_SPLIT = IW'(15);

  logic [7:0]    regs_q [GDC_N];
  logic [IW-1:0] sub;
  logic          in_rng, store, recalc_q;

  always_comb begin
    sub    = idx_q[IW-1:0];
    in_rng = (idx_q >= I_FIRST) && ({1'b0, idx_q} < LIMIT);
    store  = dat_wr && in_rng;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      bank_rd_q <= '0;
      bank_wr_q <= '0;
      recalc_q  <= 1'b0;
      for (int i = 0; i < GDC_N; i++) regs_q[i] <= '0;
    end else begin
      if (idx_wr)     idx_q     <= wdata;
      if (bank_rd_wr) bank_rd_q <= wdata;
      if (bank_wr_wr) bank_wr_q <= wdata;
      if (store)      regs_q[sub] <= wdata;
      recalc_q <= dat_wr && ((idx_q == I_TIMA) || (idx_q == I_TIMB));
    end
  end

  always_comb begin
    if (!in_rng)               rd_data = 8'hFF;
    else if (idx_q == I_TIMB)  rd_data = regs_q[sub] | 8'h04;
    else                       rd_data = regs_q[sub];
  end

  assign write_bank = bank_wr_q[BANK_W-1:0];
  assign read_bank  = regs_q[I_SPLIT][2] ? bank_rd_q[BANK_W-1:0] : bank_wr_q[BANK_W-1:0];
  assign recalc     = recalc_q;

  for (genvar g = 0; g < GDC_N; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = regs_q[g];
  end

  // Data writes outside the extended range leave the array alone
  assert_gdc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !in_rng) |=> $stable(regs_flat));

  // Write bank follows the bank port
  assert_write_bank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_wr |=> write_bank == $past(wdata[BANK_W-1:0]));

  // A recalc pulse from this file follows a data write
  assert_gdc_recalc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    recalc_q |-> $past(dat_wr));

endmodule

// File: rtl/vga_xreg_decoder.sv
module vga_xreg_decoder
  import vga_xreg_pkg::*;
#(
  parameter int CHIP_TYPE = 2,
  parameter int MEM_KB    = 1024,
  parameter int CRTC_IW   = 6,
  parameter int GDC_N     = 16,
  parameter int BANK_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [15:0]               req_addr,
  input  logic [7:0]                req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [7:0]                rsp_rdata,
  output logic [7:0]                misc_out,
  output logic [(8<<CRTC_IW)-1:0]   crtc_regs,
  output logic [8*GDC_N-1:0]        gfx_regs,
  output logic [BANK_W-1:0]         read_bank,
  output logic [BANK_W-1:0]         write_bank,
  output logic [16:0]               start_addr,
  output logic                      start_load,
  output logic                      recalc
);

  localparam int IDX_PAD = 8 - CRTC_IW;

  port_e               port;
  logic                accept, wr_acc;
  logic [7:0]          misc_q;
  logic [CRTC_IW-1:0]  crtc_idx;
  logic [7:0]          crtc_rd, gdc_idx, gdc_rd, bank_rd_q, bank_wr_q;
  logic                crtc_recalc, gdc_recalc;
  logic [7:0]          rd_mux;
  logic                rsp_valid_q;
  logic [7:0]          rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  vga_xreg_port_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (req_addr),
    .write  (req_write),
    .colour (misc_q[0]),
    .port   (port)
  );

  vga_xreg_crtc_file #(
    .CHIP_TYPE (CHIP_TYPE),
    .MEM_KB    (MEM_KB),
    .IDX_W     (CRTC_IW)
  ) u_crtc (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (wr_acc && port == PORT_CRTC_IDX),
    .dat_wr     (wr_acc && port == PORT_CRTC_DAT),
    .wdata      (req_wdata),
    .idx_q      (crtc_idx),
    .rd_data    (crtc_rd),
    .regs_flat  (crtc_regs),
    .start_addr (start_addr),
    .start_load (start_load),
    .recalc     (crtc_recalc)
  );

  vga_xreg_gfx_file #(
    .GDC_N  (GDC_N),
    .BANK_W (BANK_W)
  ) u_gfx (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (wr_acc && port == PORT_GDC_IDX),
    .dat_wr     (wr_acc && port == PORT_GDC_DAT),
    .bank_rd_wr (wr_acc && port == PORT_BANK_RD),
    .bank_wr_wr (wr_acc && port == PORT_BANK_WR),
    .wdata      (req_wdata),
    .idx_q      (gdc_idx),
    .rd_data    (gdc_rd),
    .regs_flat  (gfx_regs),
    .bank_rd_q  (bank_rd_q),
    .bank_wr_q  (bank_wr_q),
    .read_bank  (read_bank),
    .write_bank (write_bank),
    .recalc     (gdc_recalc)
  );

  always_comb begin
    case (port)
      PORT_MISC_RD:  rd_mux = misc_q;
      PORT_GDC_IDX:  rd_mux = gdc_idx;
      PORT_GDC_DAT:  rd_mux = gdc_rd;
      PORT_CRTC_IDX: rd_mux = {{IDX_PAD{1'b0}}, crtc_idx};
      PORT_CRTC_DAT: rd_mux = crtc_rd;
      PORT_BANK_RD:  rd_mux = bank_rd_q;
      PORT_BANK_WR:  rd_mux = bank_wr_q;
      default:       rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q      <= 8'h01;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (wr_acc && port == PORT_MISC_WR) misc_q <= req_wdata;
      if (accept && !req_write) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign misc_out  = misc_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign recalc    = crtc_recalc || gdc_recalc;

  // A waiting response holds its data
  assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // A read accept always yields a response next cycle
  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // Misc-output write lands in the register
  assert_misc_load_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && port == PORT_MISC_WR) |=> misc_out == $past(req_wdata));

endmodule

// File: tb/vga_xreg_decoder_tb.sv
module vga_xreg_decoder_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, rsp_ready;
  logic [15:0]  req_addr;
  logic [7:0]   req_wdata;
  logic         req_ready, rsp_valid;
  logic [7:0]   rsp_rdata, misc_out;
  logic [511:0] crtc_regs;
  logic [127:0] gfx_regs;
  logic [3:0]   read_bank, write_bank;
  logic [16:0]  start_addr;
  logic         start_load, recalc;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vga_xreg_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .misc_out(misc_out), .crtc_regs(crtc_regs), .gfx_regs(gfx_regs),
    .read_bank(read_bank), .write_bank(write_bank),
    .start_addr(start_addr), .start_load(start_load), .recalc(recalc)
  );

  // {write, addr, data, expected read, requirement number}
  localparam int NV = 38;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 16'h03D4, 8'h13, 8'h00, 8'd3},
    {1'b1, 16'h03D5, 8'h5A, 8'h00, 8'd3},
    {1'b0, 16'h03D5, 8'h00, 8'h5A, 8'd3},
    {1'b1, 16'h03D4, 8'hD3, 8'h00, 8'd3},   // R3: upper bits dropped
    {1'b0, 16'h03D4, 8'h00, 8'h13, 8'd3},
    {1'b0, 16'h03D5, 8'h00, 8'h5A, 8'd3},
    {1'b1, 16'h03D4, 8'h1A, 8'h00, 8'd7},
    {1'b1, 16'h03D5, 8'h33, 8'h00, 8'd7},
    {1'b0, 16'h03D5, 8'h00, 8'h80, 8'd7},   // R7: chip type 2 in bits 7:6
    {1'b1, 16'h03D4, 8'h1E, 8'h00, 8'd8},
    {1'b1, 16'h03D5, 8'hFF, 8'h00, 8'd8},
    {1'b0, 16'h03D5, 8'h00, 8'h02, 8'd8},   // R8: 1024 KB -> 2
    {1'b1, 16'h03CE, 8'h0C, 8'h00, 8'd9},
    {1'b1, 16'h03CF, 8'h21, 8'h00, 8'd9},
    {1'b0, 16'h03CF, 8'h00, 8'h25, 8'd9},   // R9: bit 2 forced
    {1'b1, 16'h03CE, 8'h0A, 8'h00, 8'd4},
    {1'b1, 16'h03CF, 8'h77, 8'h00, 8'd4},
    {1'b0, 16'h03CF, 8'h00, 8'h77, 8'd4},
    {1'b1, 16'h03CE, 8'h05, 8'h00, 8'd4},
    {1'b1, 16'h03CF, 8'h44, 8'h00, 8'd4},
    {1'b0, 16'h03CF, 8'h00, 8'hFF, 8'd4},   // R4: low index not stored
    {1'b1, 16'h03CE, 8'h0A, 8'h00, 8'd4},
    {1'b0, 16'h03CF, 8'h00, 8'h77, 8'd4},
    {1'b0, 16'h03CE, 8'h00, 8'h0A, 8'd4},
    {1'b1, 16'h03B4, 8'h05, 8'h00, 8'd2},   // R2: mono port while colour
    {1'b0, 16'h03D4, 8'h00, 8'h1E, 8'd2},
    {1'b0, 16'h03B4, 8'h00, 8'hFF, 8'd2},
    {1'b1, 16'h03C2, 8'h00, 8'h00, 8'd14},  // R14: switch to mono
    {1'b0, 16'h03CC, 8'h00, 8'h00, 8'd14},
    {1'b1, 16'h03B4, 8'h13, 8'h00, 8'd2},
    {1'b0, 16'h03B4, 8'h00, 8'h13, 8'd2},
    {1'b0, 16'h03B5, 8'h00, 8'h5A, 8'd2},
    {1'b0, 16'h03D4, 8'h00, 8'hFF, 8'd2},
    {1'b1, 16'h03B7, 8'h9C, 8'h00, 8'd12},
    {1'b0, 16'h03B7, 8'h00, 8'h9C, 8'd12},
    {1'b1, 16'h03C2, 8'h01, 8'h00, 8'd14},
    {1'b0, 16'h03D7, 8'h00, 8'h9C, 8'd12},
    {1'b0, 16'h03CC, 8'h00, 8'h01, 8'd14}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 misc", {24'b0, misc_out}, 32'h01);
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp", {31'b0, rsp_valid}, 32'd0);
    check("R1 crtc", {31'b0, |crtc_regs}, 32'd0);
    check("R1 gfx", {31'b0, |gfx_regs}, 32'd0);
    check("R1 strobes", {15'b0, start_addr, start_load, recalc}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:24], VEC[i][23:16]);
      else begin
        rd(VEC[i][39:24], d);
        check($sformatf("R%0d vec%0d", VEC[i][7:0], i), {24'b0, d}, {24'b0, VEC[i][15:8]});
      end
    end

    // R12: bank split
    wr(16'h03D6, 8'h35);
    check("R12 write_bank", {28'b0, write_bank}, 32'hC);
    check("R12 read_bank same", {28'b0, read_bank}, 32'hC);
    wr(16'h03CE, 8'h0F);
    wr(16'h03CF, 8'h04);
    check("R12 read_bank split", {28'b0, read_bank}, 32'h5);

    // R11: changed CRTC write pulses recalc
    wr(16'h03D4, 8'h01);
    wr(16'h03D5, 8'h11);
    check("R11 changed", {31'b0, recalc}, 32'd1);
    // R5 / R6: lock
    wr(16'h03D4, 8'h11);
    wr(16'h03D5, 8'h80);
    wr(16'h03D4, 8'h01);
    wr(16'h03D5, 8'hEE);
    check("R5 no recalc", {31'b0, recalc}, 32'd0);
    rd(16'h03D5, d);
    check("R5 locked", {24'b0, d}, 32'h11);
    wr(16'h03D4, 8'h07);
    wr(16'h03D5, 8'hFF);
    rd(16'h03D5, d);
    check("R6 bit4 only", {24'b0, d}, 32'h10);

    // R10 / R11: start address
    wr(16'h03D4, 8'h08);
    wr(16'h03D5, 8'h40);
    check("R11 idx8", {30'b0, start_load, recalc}, 32'b01);
    wr(16'h03D4, 8'h0C);
    wr(16'h03D5, 8'h12);
    check("R10 load hi", {30'b0, start_load, recalc}, 32'b10);
    check("R10 addr hi", {15'b0, start_addr}, 32'h1202);
    wr(16'h03D4, 8'h0D);
    wr(16'h03D5, 8'hFF);
    check("R10 addr lo", {15'b0, start_addr}, 32'h1301);
    wr(16'h03D5, 8'hFF);
    check("R10 unchanged", {31'b0, start_load}, 32'd0);
    wr(16'h03D4, 8'h0E);
    wr(16'h03D5, 8'h55);
    check("R11 cursor skip", {31'b0, recalc}, 32'd0);
    wr(16'h03D4, 8'h13);
    wr(16'h03D5, 8'h5A);
    check("R11 same value", {31'b0, recalc}, 32'd0);
    wr(16'h03CE, 8'h0B);
    wr(16'h03CF, 8'h00);
    check("R11 gdc 0B", {31'b0, recalc}, 32'd1);

    // R13: back-pressure, drain and accept in one edge
    wr(16'h03D4, 8'h0E);
    rsp_ready = 1'b0;
    rd(16'h03D4, d);
    check("R13 valid held", {31'b0, rsp_valid}, 32'd1);
    check("R13 ready low", {31'b0, req_ready}, 32'd0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h03CE;
    @(posedge clk);
    @(negedge clk);
    check("R13 data stable", {24'b0, rsp_rdata}, 32'h0E);
    check("R13 still blocked", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 next valid", {31'b0, rsp_valid}, 32'd1);
    check("R13 next data", {24'b0, rsp_rdata}, 32'h0B);
    @(negedge clk);
    check("R13 drained", {31'b0, rsp_valid}, 32'd0);

    finish_run();
  end

endmodule